// File: doc/BRIEF.md
# E3 Overhead Bit Serial Output Port

This block takes the twelve overhead bits of each received E3 frame and hands them to external data-link equipment as a serial stream. The receive framer delivers a complete overhead word with a one-cycle strobe. The word holds a 10-bit frame alignment pattern, the alarm (A) bit and the national (N) bit. The block latches the word into a holding register. At the next frame boundary of the output stream it moves the word into a shift register.

The output port has three pins: a free-running overhead clock divided down from the system clock, a serial data pin, and a start-of-frame marker. Data and marker change only when the overhead clock falls, so the far end samples them on the rising edge. The marker is high for one overhead-clock period, during which the first bit of a frame is on the data pin. When no word is waiting, the data pin and the marker stay low and the clock keeps running. A sticky flag records when a word was overwritten before it could be sent.

Top module: `e3oh_serial_out`

## Requirements
- R1: `oh_data` and `oh_sof` change only on the system clock edge at which `oh_clk` goes from 1 to 0, and they stay stable through the whole high phase of `oh_clk`.
- R2: `oh_clk` runs continuously with a period of DIV_RATIO system clock cycles (default 8), high for DIV_RATIO/2 cycles and low for DIV_RATIO/2 cycles.
- R3: `oh_sof` is high at exactly one rising edge of `oh_clk` per frame, and that is the edge at which the frame's first bit is on `oh_data`.
- R4: Counting rising edges of `oh_clk` from k=0 at the edge where `oh_sof` is high, `oh_data` carries `fas_in[9-k]` for k=0..9, `a_in` at k=10 and `n_in` at k=11.
- R5: A strobe that arrives while a frame is being shifted does not alter that frame. The newly held word starts at the rising edge right after the 12th bit, with no gap between the two frames.
- R6: When a 12-bit frame ends and no word is held, `oh_data` and `oh_sof` stay low at every rising edge until a word arrives, and `oh_clk` keeps toggling.
- R7: When a second strobe arrives before the held word has been moved into the shifter, the newer word replaces the older one, which is never sent, and `overrun` goes high and stays high.
- R8: `ovr_clr` high for one cycle clears `overrun`. If a new overrun occurs in the same cycle, the set wins and `overrun` stays high.
- R9: Synchronous active-high `rst` drives `oh_clk`, `oh_data`, `oh_sof` and `overrun` low and discards any held word, so no frame follows the reset until a new strobe arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| oh_strobe | input | 1 | One-cycle pulse: overhead word on `fas_in`, `a_in`, `n_in` is valid |
| fas_in | input | 10 | Frame alignment pattern, bit 9 sent first |
| a_in | input | 1 | Alarm bit of the frame |
| n_in | input | 1 | National bit of the frame |
| ovr_clr | input | 1 | Clears the sticky overrun flag |
| oh_clk | output | 1 | Free-running overhead clock |
| oh_data | output | 1 | Serial overhead data, changes on the falling edge of `oh_clk` |
| oh_sof | output | 1 | Start-of-frame marker, high for one `oh_clk` period |
| overrun | output | 1 | Sticky flag: a held word was overwritten before it was sent |

## Verification
On every system clock cycle, the embedded properties check these behaviours: the data and marker change only together with a falling overhead clock, each half period of the clock has the right length, the marker never lasts past one period, idle output stays low, a running frame is never cut short, and the overrun flag is only raised by a strobe that lands on a held word and is only cleared as the flag's rules allow. Some behaviours are matters of content and order rather than timing, and only the bench scenarios can show them. These are the exact 12-bit order of each frame, that frames sent back to back have no gap, which of several overwritten words reaches the pin, and that a held word is discarded by reset.

// File: rtl/e3oh_pkg.sv
package e3oh_pkg;
  localparam int FAS_W = 10;
  localparam int OH_W  = FAS_W + 2;

  typedef logic [OH_W-1:0] oh_word_t;

  // Transmission order is MSB first: FAS[9..0], then A, then N.
  function automatic oh_word_t oh_pack(input logic [FAS_W-1:0] fas,
                                       input logic a, input logic n);
    return {fas, a, n};
  endfunction

  function automatic int unsigned half_period(input int unsigned ratio);
    return ratio / 2;
  endfunction
endpackage

// File: rtl/e3oh_clkdiv.sv
module e3oh_clkdiv #(
  parameter int unsigned DIV_RATIO = 8
) (
  input  logic clk,
  input  logic rst,
  output logic oh_clk,
  output logic rise_en,
  output logic fall_en
);
  import e3oh_pkg::*;
  localparam int unsigned HALF  = half_period(DIV_RATIO);
  localparam int unsigned CNT_W = (DIV_RATIO > 2) ? $clog2(DIV_RATIO) : 1;

  logic [CNT_W-1:0] cnt;

  assign rise_en = (cnt == CNT_W'(HALF - 1));
  assign fall_en = (cnt == CNT_W'(DIV_RATIO - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      oh_clk <= 1'b0;
    end else begin
      cnt <= fall_en ? '0 : cnt + 1'b1;
      if (rise_en)      oh_clk <= 1'b1;
      else if (fall_en) oh_clk <= 1'b0;
    end
  end

  // Checker: count cycles spent at each level of oh_clk.
  logic             clk_d;
  logic [CNT_W-1:0] run;
  always_ff @(posedge clk) begin
    if (rst) begin
      clk_d <= 1'b0;
      run   <= '0;
    end else begin
      clk_d <= oh_clk;
      run   <= (oh_clk != clk_d) ? CNT_W'(1) : run + 1'b1;
    end
  end

  a_r2_half_period: assert property (@(posedge clk) disable iff (rst)
    (oh_clk != clk_d) |-> (run == CNT_W'(HALF)))
    else $error("oh_clk level did not last half a period");
endmodule

// File: rtl/e3oh_hold.sv
module e3oh_hold
  import e3oh_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     strobe,
  input  oh_word_t word_in,
  input  logic     take,
  input  logic     ovr_clr,
  output oh_word_t hold_word,
  output logic     hold_valid,
  output logic     overrun
);
  // A strobe that finds a word still waiting (and not leaving now) loses it.
  logic lost_word;
  assign lost_word = strobe && hold_valid && !take;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_word  <= '0;
      hold_valid <= 1'b0;
      overrun    <= 1'b0;
    end else begin
      if (strobe) hold_word <= word_in;
      hold_valid <= strobe || (hold_valid && !take);
      if (lost_word)    overrun <= 1'b1;
      else if (ovr_clr) overrun <= 1'b0;
    end
  end

  a_r7_overrun_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun) |-> ($past(strobe) && $past(hold_valid)))
    else $error("overrun raised without a lost word");

  a_r7_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
    (overrun && !ovr_clr) |=> overrun)
    else $error("overrun dropped without a clear");

  a_r8_clear_works: assert property (@(posedge clk) disable iff (rst)
    (ovr_clr && !strobe) |=> !overrun)
    else $error("overrun not cleared");
endmodule

// File: rtl/e3oh_shift.sv
module e3oh_shift
  import e3oh_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     fall_en,
  input  oh_word_t hold_word,
  input  logic     hold_valid,
  output logic     take,
  output logic     active,
  output logic     oh_data,
  output logic     oh_sof
);
  localparam int IDX_W = $clog2(OH_W);

  oh_word_t   shreg;
  logic [IDX_W-1:0] idx;
  logic       last_bit;
  logic       boundary;

  assign last_bit = (idx == IDX_W'(OH_W - 1));
  assign boundary = !active || last_bit;
  assign take     = fall_en && hold_valid && boundary;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg   <= '0;
      idx     <= '0;
      active  <= 1'b0;
      oh_data <= 1'b0;
      oh_sof  <= 1'b0;
    end else if (fall_en) begin
      if (boundary) begin
        if (hold_valid) begin
          oh_data <= hold_word[OH_W-1];
          shreg   <= hold_word << 1;
          idx     <= '0;
          active  <= 1'b1;
          oh_sof  <= 1'b1;
        end else begin
          oh_data <= 1'b0;
          active  <= 1'b0;
          oh_sof  <= 1'b0;
        end
      end else begin
        oh_data <= shreg[OH_W-1];
        shreg   <= shreg << 1;
        idx     <= idx + 1'b1;
        oh_sof  <= 1'b0;
      end
    end
  end

  a_r6_idle_low: assert property (@(posedge clk) disable iff (rst)
    !active |-> (!oh_data && !oh_sof))
    else $error("idle output not low");

  a_r3_sof_single: assert property (@(posedge clk) disable iff (rst)
    (oh_sof && fall_en) |=> !oh_sof)
    else $error("marker held past one period");

  a_r5_frame_unbroken: assert property (@(posedge clk) disable iff (rst)
    (active && !last_bit && fall_en) |=> active)
    else $error("frame cut short");
endmodule

// File: rtl/e3oh_serial_out.sv
module e3oh_serial_out #(
  parameter int unsigned DIV_RATIO = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       oh_strobe,
  input  logic [9:0] fas_in,
  input  logic       a_in,
  input  logic       n_in,
  input  logic       ovr_clr,
  output logic       oh_clk,
  output logic       oh_data,
  output logic       oh_sof,
  output logic       overrun
);
  import e3oh_pkg::*;

  // Named internal events
  logic     rise_en;
  logic     fall_en;
  logic     take;
  logic     active;
  logic     hold_valid;
  oh_word_t hold_word;
  oh_word_t word_in;

  assign word_in = oh_pack(fas_in, a_in, n_in);

  e3oh_clkdiv #(.DIV_RATIO(DIV_RATIO)) u_div (
    .clk     (clk),
    .rst     (rst),
    .oh_clk  (oh_clk),
    .rise_en (rise_en),
    .fall_en (fall_en)
  );

  e3oh_hold u_hold (
    .clk        (clk),
    .rst        (rst),
    .strobe     (oh_strobe),
    .word_in    (word_in),
    .take       (take),
    .ovr_clr    (ovr_clr),
    .hold_word  (hold_word),
    .hold_valid (hold_valid),
    .overrun    (overrun)
  );

  e3oh_shift u_shift (
    .clk        (clk),
    .rst        (rst),
    .fall_en    (fall_en),
    .hold_word  (hold_word),
    .hold_valid (hold_valid),
    .take       (take),
    .active     (active),
    .oh_data    (oh_data),
    .oh_sof     (oh_sof)
  );

  a_r1_data_on_fall: assert property (@(posedge clk) disable iff (rst)
    !$stable(oh_data) |-> $fell(oh_clk))
    else $error("data changed away from a falling oh_clk");

  a_r1_sof_on_fall: assert property (@(posedge clk) disable iff (rst)
    !$stable(oh_sof) |-> $fell(oh_clk))
    else $error("marker changed away from a falling oh_clk");

  a_r2_no_rise_on_launch: assert property (@(posedge clk) disable iff (rst)
    rise_en |-> !fall_en)
    else $error("rise and fall enables collided");
endmodule

// File: tb/test_e3oh_serial_out.sv
`timescale 1ns/1ps
module test_e3oh_serial_out;
  localparam int unsigned DIV = 8;
  localparam real TCLK = 4.0;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       oh_strobe = 1'b0;
  logic [9:0] fas_in = '0;
  logic       a_in = 1'b0;
  logic       n_in = 1'b0;
  logic       ovr_clr = 1'b0;
  logic       oh_clk, oh_data, oh_sof, overrun;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  e3oh_serial_out #(.DIV_RATIO(DIV)) i_e3oh_serial_out (
    .clk(clk), .rst(rst), .oh_strobe(oh_strobe), .fas_in(fas_in),
    .a_in(a_in), .n_in(n_in), .ovr_clr(ovr_clr), .oh_clk(oh_clk),
    .oh_data(oh_data), .oh_sof(oh_sof), .overrun(overrun)
  );

  // Stimulus table: FAS in [11:2], A in [1], N in [0].
  localparam logic [11:0] VEC [7] = '{12'hF6B, 12'h000, 12'hFFF, 12'hAAA,
                                      12'h555, 12'h801, 12'h003};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected bit seen at rising edge k of a frame (bench's own statement of R4).
  function automatic logic want_bit(input logic [9:0] f, input logic a,
                                    input logic n, input int k);
    if (k < 10)       return f[9-k];
    else if (k == 10) return a;
    else              return n;
  endfunction

  function automatic logic [11:0] want_frame(input logic [9:0] f, input logic a, input logic n);
    logic [11:0] w;
    for (int k = 0; k < 12; k++) w[11-k] = want_bit(f, a, n, k);
    return w;
  endfunction

  task automatic send(input logic [9:0] f, input logic a, input logic n, input logic clr_too);
    @(negedge clk);
    fas_in = f; a_in = a; n_in = n; oh_strobe = 1'b1; ovr_clr = clr_too;
    @(negedge clk);
    oh_strobe = 1'b0; ovr_clr = 1'b0;
  endtask

  // Collect one frame; bits[11-k] holds the bit of edge k.
  task automatic capture(input int max_wait, output logic [11:0] bits,
                         output int sofs, output bit found);
    found = 0; sofs = 0; bits = '0;
    for (int w = 0; w < max_wait && !found; w++) begin
      @(posedge oh_clk); #1;
      if (oh_sof) found = 1;
    end
    if (found) begin
      bits[11] = oh_data; sofs = 1;
      for (int k = 1; k < 12; k++) begin
        @(posedge oh_clk); #1;
        bits[11-k] = oh_data;
        if (oh_sof) sofs++;
      end
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [11:0] got;
    int sofs;
    bit found;
    realtime t0, t1, t2;
    logic d_early;

    // R9: reset state
    repeat (5) @(posedge clk);
    #1;
    check("R9 oh_clk in reset", oh_clk, 0);
    check("R9 oh_data in reset", oh_data, 0);
    check("R9 oh_sof in reset", oh_sof, 0);
    check("R9 overrun in reset", overrun, 0);
    @(negedge clk); rst = 1'b0;

    // R2: period and duty
    @(posedge oh_clk); t0 = $realtime;
    @(negedge oh_clk); t1 = $realtime;
    @(posedge oh_clk); t2 = $realtime;
    check("R2 period ns", int'(t2 - t0), int'(DIV * TCLK));
    check("R2 high ns", int'(t1 - t0), int'(DIV * TCLK / 2));

    // R6: idle before any word
    for (int i = 0; i < 6; i++) begin
      @(posedge oh_clk); #1;
      check("R6 idle data", oh_data, 0);
      check("R6 idle sof", oh_sof, 0);
    end

    // R3/R4: vector table
    foreach (VEC[v]) begin
      send(VEC[v][11:2], VEC[v][1], VEC[v][0], 1'b0);
      capture(40, got, sofs, found);
      check("R3 frame started", found, 1);
      check("R4 bit order", got, want_frame(VEC[v][11:2], VEC[v][1], VEC[v][0]));
      check("R3 one marker per frame", sofs, 1);
      @(posedge oh_clk); #1;
      check("R6 idle after frame", {oh_data, oh_sof}, 2'b00);
    end

    // R1: data steady through high phase
    send(10'h2D5, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 14; i++) begin
      @(posedge oh_clk); #1;
      d_early = oh_data;
      #(DIV * TCLK / 2 - 2.0);
      check("R1 stable high phase", oh_data, d_early);
    end

    // R5: back-to-back frames, strobe during shifting
    send(10'h3C1, 1'b0, 1'b1, 1'b0);
    fork
      capture(40, got, sofs, found);
      begin
        @(posedge oh_sof); repeat (3) @(posedge oh_clk);
        send(10'h0F3, 1'b1, 1'b1, 1'b0);
      end
    join
    check("R5 first frame intact", got, want_frame(10'h3C1, 1'b0, 1'b1));
    capture(1, got, sofs, found);
    check("R5 no gap", found, 1);
    check("R5 second frame", got, want_frame(10'h0F3, 1'b1, 1'b1));
    check("R7 no overrun when loaded in time", overrun, 0);

    // R7/R8: overwrite, clear, set-wins
    send(10'h155, 1'b0, 1'b0, 1'b0);
    fork
      capture(40, got, sofs, found);
      begin
        @(posedge oh_sof); repeat (2) @(posedge oh_clk);
        send(10'h111, 1'b0, 1'b0, 1'b0);
        check("R7 no overrun on first hold", overrun, 0);
        send(10'h222, 1'b1, 1'b0, 1'b0);
        check("R7 overrun set", overrun, 1);
        @(negedge clk); ovr_clr = 1'b1; @(negedge clk); ovr_clr = 1'b0;
        check("R8 cleared", overrun, 0);
        repeat (3) @(negedge clk);
        check("R7 sticky stays low after clear", overrun, 0);
        send(10'h3A5, 1'b0, 1'b1, 1'b1);
        check("R8 set wins over clear", overrun, 1);
      end
    join
    check("R5 frame unaffected by strobes", got, want_frame(10'h155, 1'b0, 1'b0));
    capture(1, got, sofs, found);
    check("R7 newest word sent", got, want_frame(10'h3A5, 1'b0, 1'b1));
    check("R7 sticky", overrun, 1);
    @(posedge oh_clk); #1;
    check("R6 idle after overwritten words", {oh_data, oh_sof}, 2'b00);

    // R9: reset mid-frame discards held word
    send(10'h3FF, 1'b1, 1'b1, 1'b0);
    @(posedge oh_sof); repeat (2) @(posedge oh_clk);
    send(10'h3FF, 1'b1, 1'b1, 1'b0);
    @(negedge clk); rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R9 data after reset", oh_data, 0);
    check("R9 sof after reset", oh_sof, 0);
    check("R9 clk after reset", oh_clk, 0);
    check("R9 overrun after reset", overrun, 0);
    @(negedge clk); rst = 1'b0;
    found = 0;
    for (int i = 0; i < 30; i++) begin
      @(posedge oh_clk); #1;
      if (oh_sof || oh_data) found = 1;
    end
    check("R9 held word discarded", found, 0);

    done = 1;
    summary();
    $finish;
  end
endmodule